// File: doc/BRIEF.md
# Paired Pre-Add Integer Tile Multiplier

This block computes one tile of a signed integer matrix product, C = A x B, where A has ROWS rows and B has COLS columns, both with a shared length KD. It does not spend one multiplier on each product term. Each output element is built from products of cross-paired sums, one multiply per pair of indices along the shared dimension. Two correction terms then remove the unwanted parts: one for each row of A and one for each column of B. For a pair (p, q) of shared indices the block multiplies (a[p] + b[q]) by (a[q] + b[p]). When these products are summed over all pairs, subtracting the sum of a[p]*a[q] and the sum of b[p]*b[q] leaves the exact inner product.

Rows of A and columns of B arrive on two valid/ready streams. Each row's correction and each column's correction is formed once, while that vector is accepted. It is stored next to the vector and reused for every output element that needs it. A compute phase then produces one element per cycle and writes it into a bank of accumulators. A drain phase streams the finished tile out in row-major order. The accumulate enable lets successive slices of a long shared dimension add into the same accumulators. A clear input discards the tile in progress.

Top module: `fip_matmul`

## Requirements
- R1: After reset, a_ready and b_ready are 1 and o_valid is 0.
- R2: Element k of an A row, or of a B column, sits at bits [k*DW +: DW] of a_data or b_data. Once ROWS rows are held, a_ready stays 0 until the tile has drained, and b_ready does the same once COLS columns are held. No operand is accepted while o_valid is 1.
- R3: Each o_data equals the two's-complement sum over k of A[i][k]*B[k][j], with no loss. This includes operands that are all at the most negative value.
- R4: When KD is odd, the missing partner of the last index is taken as zero and the results remain exact.
- R5: Outputs leave in row-major order, element e = i*COLS + j. o_last is 1 on element ROWS*COLS-1 and on no other element.
- R6: While o_valid is 1 and o_ready is 0, o_valid, o_data and o_last hold their values.
- R7: acc_en must be held steady while a tile loads. With acc_en at 1, the tile's products are added to the values the accumulators already hold. With acc_en at 0, the products replace those values.
- R8: A one-cycle clr throws away any operands already loaded and zeroes every accumulator and correction. In the next cycle o_valid is 0 and both ready signals are 1. A following tile loaded with acc_en at 1 then yields only its own product.
- R9: In the cycle after the handshake of the element flagged o_last, a_ready and b_ready are 1 and o_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the tile, accumulators and corrections |
| acc_en | input | 1 | 1: add the tile to the held results; 0: replace them |
| a_valid | input | 1 | An A row is offered |
| a_ready | output | 1 | An A row can be accepted |
| a_data | input | KD*DW | One row of A, element k at bits [k*DW +: DW] |
| b_valid | input | 1 | A B column is offered |
| b_ready | output | 1 | A B column can be accepted |
| b_data | input | KD*DW | One column of B, element k at bits [k*DW +: DW] |
| o_valid | output | 1 | A result element is offered |
| o_ready | input | 1 | The consumer takes the offered element |
| o_data | output | ACC_W | Signed result element |
| o_last | output | 1 | Marks the final element of the tile |

## Verification
The bench builds two copies of the block. The first keeps the defaults: 8-bit operands, a 4x4 tile and an even shared length of 8. It covers random tiles, tiles made entirely of the most negative value, chaining with acc_en, back-pressure and a clear in the middle of a load. The second uses a 2x3 tile with a shared length of 5. The odd length makes the zero-padding path generate, and the width of the row and column index counters no longer matches the tile size. Both copies are checked against a plain multiply-accumulate model kept in the bench.

// File: rtl/fip_pkg.sv
package fip_pkg;

   typedef enum logic [1:0] {
      FIP_LOAD  = 2'd0,
      FIP_CALC  = 2'd1,
      FIP_DRAIN = 2'd2
   } fip_phase_e;

   function automatic int fip_max(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/fip_pair_corr.sv
// Correction sum of one vector: sum over pairs p of v[2p] * v[2p+1].
module fip_pair_corr #(
   parameter int DW    = 8,
   parameter int KP    = 8,
   parameter int SUM_W = 21
) (
   input  logic [KP*DW-1:0]        vec,
   output logic signed [SUM_W-1:0] corr
);
   localparam int PAIRS = KP / 2;
   localparam int CP_W  = 2 * DW;

   logic signed [CP_W-1:0] cp [PAIRS];

   for (genvar p = 0; p < PAIRS; p++) begin : g_cp
      logic signed [DW-1:0] lo;
      logic signed [DW-1:0] hi;
      assign lo    = $signed(vec[2*p*DW +: DW]);
      assign hi    = $signed(vec[(2*p+1)*DW +: DW]);
      assign cp[p] = CP_W'(lo) * CP_W'(hi);
   end

   always_comb begin
      corr = '0;
      for (int p = 0; p < PAIRS; p++) begin
         corr = corr + SUM_W'(cp[p]);
      end
   end
endmodule

// File: rtl/fip_pair_dot.sv
// Sum over pairs of (a[2p] + b[2p+1]) * (a[2p+1] + b[2p]).
module fip_pair_dot #(
   parameter int DW    = 8,
   parameter int KP    = 8,
   parameter int SUM_W = 21
) (
   input  logic [KP*DW-1:0]        a_vec,
   input  logic [KP*DW-1:0]        b_vec,
   output logic signed [SUM_W-1:0] dot
);
   localparam int PAIRS  = KP / 2;
   localparam int PRE_W  = DW + 1;
   localparam int PROD_W = 2 * PRE_W;

   logic signed [PROD_W-1:0] prod [PAIRS];

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic signed [DW-1:0]    a0, a1, b0, b1;
      logic signed [PRE_W-1:0] s0, s1;
      assign a0 = $signed(a_vec[2*p*DW +: DW]);
      assign a1 = $signed(a_vec[(2*p+1)*DW +: DW]);
      assign b0 = $signed(b_vec[2*p*DW +: DW]);
      assign b1 = $signed(b_vec[(2*p+1)*DW +: DW]);
      assign s0 = PRE_W'(a0) + PRE_W'(b1);
      assign s1 = PRE_W'(a1) + PRE_W'(b0);
      assign prod[p] = PROD_W'(s0) * PROD_W'(s1);
   end

   always_comb begin
      dot = '0;
      for (int p = 0; p < PAIRS; p++) begin
         dot = dot + SUM_W'(prod[p]);
      end
   end
endmodule

// File: rtl/fip_acc_bank.sv
// One accumulator per output element; a write either adds to or replaces the entry.
module fip_acc_bank #(
   parameter int ACC_W  = 24,
   parameter int CELLS  = 16,
   parameter int CELL_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr_en,
   input  logic                    keep,
   input  logic [CELL_W-1:0]       wr_idx,
   input  logic signed [ACC_W-1:0] wr_val,
   input  logic [CELL_W-1:0]       rd_idx,
   output logic signed [ACC_W-1:0] rd_val
);
   logic signed [ACC_W-1:0] mem [CELLS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < CELLS; c++) mem[c] <= '0;
      end else if (clr) begin
         for (int c = 0; c < CELLS; c++) mem[c] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= (keep ? mem[wr_idx] : '0) + wr_val;
      end
   end

   assign rd_val = mem[rd_idx];
endmodule

// File: rtl/fip_matmul.sv
module fip_matmul
   import fip_pkg::*;
#(
   parameter int DW    = 8,
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int KD    = 8,
   parameter int ACC_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                acc_en,
   input  logic                a_valid,
   output logic                a_ready,
   input  logic [KD*DW-1:0]    a_data,
   input  logic                b_valid,
   output logic                b_ready,
   input  logic [KD*DW-1:0]    b_data,
   output logic                o_valid,
   input  logic                o_ready,
   output logic [ACC_W-1:0]    o_data,
   output logic                o_last
);
   localparam int KP     = KD + (KD % 2);
   localparam int PAIRS  = KP / 2;
   localparam int PROD_W = 2 * (DW + 1);
   localparam int SUM_W  = PROD_W + $clog2(PAIRS) + 1;
   localparam int WIDE   = fip_max(SUM_W + 2, ACC_W);
   localparam int CELLS  = ROWS * COLS;
   localparam int CELL_W = $clog2(CELLS);
   localparam int RIDX_W = $clog2(ROWS);
   localparam int CIDX_W = $clog2(COLS);
   localparam int ACNT_W = $clog2(ROWS + 1);
   localparam int BCNT_W = $clog2(COLS + 1);

   // elaboration-time parameter checks
   if (DW < 2) begin : g_bad_dw
      $error("fip_matmul: DW must be at least 2");
   end
   if (ROWS < 2 || COLS < 2) begin : g_bad_tile
      $error("fip_matmul: ROWS and COLS must be at least 2");
   end
   if (KD < 1) begin : g_bad_kd
      $error("fip_matmul: KD must be at least 1");
   end
   if (ACC_W < 2 * DW + $clog2(KD) + 1) begin : g_bad_acc
      $error("fip_matmul: ACC_W too narrow for one tile");
   end

   // zero pad to an even shared length
   logic [KP*DW-1:0] a_pad, b_pad;
   if (KD % 2 == 1) begin : g_pad
      assign a_pad = {{DW{1'b0}}, a_data};
      assign b_pad = {{DW{1'b0}}, b_data};
   end else begin : g_nopad
      assign a_pad = a_data;
      assign b_pad = b_data;
   end

   // corrections formed while operands stream in
   logic signed [SUM_W-1:0] a_corr, b_corr;

   fip_pair_corr #(.DW(DW), .KP(KP), .SUM_W(SUM_W)) u_acorr (
      .vec  (a_pad),
      .corr (a_corr)
   );

   fip_pair_corr #(.DW(DW), .KP(KP), .SUM_W(SUM_W)) u_bcorr (
      .vec  (b_pad),
      .corr (b_corr)
   );

   // operand and correction storage
   fip_phase_e              phase;
   logic [KP*DW-1:0]        row_q   [ROWS];
   logic signed [SUM_W-1:0] rcorr_q [ROWS];
   logic [KP*DW-1:0]        col_q   [COLS];
   logic signed [SUM_W-1:0] ccorr_q [COLS];
   logic [ACNT_W-1:0]       a_cnt;
   logic [BCNT_W-1:0]       b_cnt;
   logic [RIDX_W-1:0]       ci;
   logic [CIDX_W-1:0]       cj;
   logic [CELL_W-1:0]       ce;
   logic [CELL_W-1:0]       oe;
   logic                    keep_q;

   logic a_fire, b_fire, o_fire, loaded;

   assign a_ready = (phase == FIP_LOAD) && (a_cnt < ACNT_W'(ROWS));
   assign b_ready = (phase == FIP_LOAD) && (b_cnt < BCNT_W'(COLS));
   assign a_fire  = a_valid && a_ready;
   assign b_fire  = b_valid && b_ready;
   assign loaded  = (a_cnt == ACNT_W'(ROWS)) && (b_cnt == BCNT_W'(COLS));
   assign o_valid = (phase == FIP_DRAIN);
   assign o_last  = o_valid && (oe == CELL_W'(CELLS - 1));
   assign o_fire  = o_valid && o_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= FIP_LOAD;
         a_cnt  <= '0;
         b_cnt  <= '0;
         ci     <= '0;
         cj     <= '0;
         ce     <= '0;
         oe     <= '0;
         keep_q <= 1'b0;
         for (int r = 0; r < ROWS; r++) begin
            row_q[r]   <= '0;
            rcorr_q[r] <= '0;
         end
         for (int c = 0; c < COLS; c++) begin
            col_q[c]   <= '0;
            ccorr_q[c] <= '0;
         end
      end else if (clr) begin
         phase  <= FIP_LOAD;
         a_cnt  <= '0;
         b_cnt  <= '0;
         ci     <= '0;
         cj     <= '0;
         ce     <= '0;
         oe     <= '0;
         keep_q <= 1'b0;
         for (int r = 0; r < ROWS; r++) rcorr_q[r] <= '0;
         for (int c = 0; c < COLS; c++) ccorr_q[c] <= '0;
      end else begin
         case (phase)
            FIP_LOAD: begin
               if (a_fire) begin
                  row_q[a_cnt[RIDX_W-1:0]]   <= a_pad;
                  rcorr_q[a_cnt[RIDX_W-1:0]] <= a_corr;
                  a_cnt <= a_cnt + 1'b1;
               end
               if (b_fire) begin
                  col_q[b_cnt[CIDX_W-1:0]]   <= b_pad;
                  ccorr_q[b_cnt[CIDX_W-1:0]] <= b_corr;
                  b_cnt <= b_cnt + 1'b1;
               end
               if (loaded) begin
                  phase  <= FIP_CALC;
                  keep_q <= acc_en;
                  ci     <= '0;
                  cj     <= '0;
                  ce     <= '0;
               end
            end
            FIP_CALC: begin
               if (cj == CIDX_W'(COLS - 1)) begin
                  cj <= '0;
                  ci <= ci + 1'b1;
               end else begin
                  cj <= cj + 1'b1;
               end
               ce <= ce + 1'b1;
               if (ce == CELL_W'(CELLS - 1)) begin
                  phase <= FIP_DRAIN;
                  oe    <= '0;
               end
            end
            FIP_DRAIN: begin
               if (o_fire) begin
                  oe <= oe + 1'b1;
                  if (o_last) begin
                     phase <= FIP_LOAD;
                     a_cnt <= '0;
                     b_cnt <= '0;
                  end
               end
            end
            default: phase <= FIP_LOAD;
         endcase
      end
   end

   // one output element per compute cycle
   logic signed [SUM_W-1:0] dot;
   logic signed [WIDE-1:0]  tile_full;
   logic signed [ACC_W-1:0] tile_val;
   logic signed [ACC_W-1:0] rd_val;

   fip_pair_dot #(.DW(DW), .KP(KP), .SUM_W(SUM_W)) u_dot (
      .a_vec (row_q[ci]),
      .b_vec (col_q[cj]),
      .dot   (dot)
   );

   assign tile_full = WIDE'(dot) - WIDE'(rcorr_q[ci]) - WIDE'(ccorr_q[cj]);
   assign tile_val  = $signed(tile_full[ACC_W-1:0]);

   fip_acc_bank #(.ACC_W(ACC_W), .CELLS(CELLS), .CELL_W(CELL_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .wr_en  (phase == FIP_CALC),
      .keep   (keep_q),
      .wr_idx (ce),
      .wr_val (tile_val),
      .rd_idx (oe),
      .rd_val (rd_val)
   );

   assign o_data = rd_val;
endmodule

// File: rtl/fip_matmul_chk.sv
module fip_matmul_chk #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int ACC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             a_valid,
   input logic             a_ready,
   input logic             b_valid,
   input logic             b_ready,
   input logic             o_valid,
   input logic             o_ready,
   input logic [ACC_W-1:0] o_data,
   input logic             o_last
);
   localparam int CELLS = ROWS * COLS;

   int a_seen, b_seen, out_cnt;
   logic tile_end;

   assign tile_end = o_valid && o_ready && o_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_seen  <= 0;
         b_seen  <= 0;
         out_cnt <= 0;
      end else if (clr || tile_end) begin
         a_seen  <= 0;
         b_seen  <= 0;
         out_cnt <= 0;
      end else begin
         if (a_valid && a_ready) a_seen <= a_seen + 1;
         if (b_valid && b_ready) b_seen <= b_seen + 1;
         if (o_valid && o_ready) out_cnt <= out_cnt + 1;
      end
   end

   // R2
   p_row_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_seen == ROWS) |-> !a_ready);
   p_col_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (b_seen == COLS) |-> !b_ready);
   p_no_intake_r2: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (!a_ready && !b_ready));
   // R5
   p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_last) |-> (out_cnt == CELLS - 1));
   p_last_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && out_cnt == CELLS - 1) |-> o_last);
   // R6
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_ready && !clr) |=> (o_valid && $stable(o_data) && $stable(o_last)));
   // R8
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!o_valid && a_ready && b_ready));
   // R9
   p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_end && !clr) |=> (a_ready && b_ready && !o_valid));
endmodule

bind fip_matmul fip_matmul_chk #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .a_valid (a_valid),
   .a_ready (a_ready),
   .b_valid (b_valid),
   .b_ready (b_ready),
   .o_valid (o_valid),
   .o_ready (o_ready),
   .o_data  (o_data),
   .o_last  (o_last)
);

// File: tb/fip_matmul_test.sv
module fip_matmul_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic acc_en = 1'b0;
   logic o_ready = 1'b0;

   // default instance: 4x4, K = 8
   logic        a_valid = 1'b0, b_valid = 1'b0;
   logic [63:0] a_data = '0, b_data = '0;
   logic        a_ready, b_ready, o_valid, o_last;
   logic [23:0] o_data;

   // odd instance: 2x3, K = 5
   logic        a2_valid = 1'b0, b2_valid = 1'b0;
   logic [39:0] a2_data = '0, b2_data = '0;
   logic        a2_ready, b2_ready, o2_valid, o2_last;
   logic [23:0] o2_data;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   int     A [4][8];
   int     B [8][4];
   longint expm [4][4];
   int     A2 [2][5];
   int     B2 [5][3];
   longint exp2 [2][3];

   always #(CLK_PERIOD/2) clk = ~clk;

   fip_matmul uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
      .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
      .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last)
   );

   fip_matmul #(.DW(8), .ROWS(2), .COLS(3), .KD(5), .ACC_W(24)) uut_odd (
      .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
      .a_valid(a2_valid), .a_ready(a2_ready), .a_data(a2_data),
      .b_valid(b2_valid), .b_ready(b2_ready), .b_data(b2_data),
      .o_valid(o2_valid), .o_ready(o_ready), .o_data(o2_data), .o_last(o2_last)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic send_a_row(input int i);
      @(negedge clk);
      a_valid = 1'b1;
      for (int k = 0; k < 8; k++) a_data[k*8 +: 8] = 8'(A[i][k]);
      while (!a_ready) @(negedge clk);
      @(posedge clk);
      #1 a_valid = 1'b0;
   endtask

   // one tile on the default instance; req names the data requirement
   task automatic main_tile(input bit accum, input bit stall, input string req);
      longint dot, got;
      logic [23:0] hold;
      acc_en = accum;
      for (int i = 0; i < 4; i++) send_a_row(i);
      @(negedge clk);
      check(!a_ready, "R2", longint'(a_ready), 0);
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         b_valid = 1'b1;
         for (int k = 0; k < 8; k++) b_data[k*8 +: 8] = 8'(B[k][j]);
         while (!b_ready) @(negedge clk);
         @(posedge clk);
         #1 b_valid = 1'b0;
      end
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) begin
            dot = 0;
            for (int k = 0; k < 8; k++) dot += longint'(A[i][k]) * longint'(B[k][j]);
            expm[i][j] = (accum ? expm[i][j] : 0) + dot;
         end
      for (int e = 0; e < 16; e++) begin
         @(negedge clk);
         if (stall && (e % 5 == 1)) begin
            o_ready = 1'b0;
            while (!o_valid) @(negedge clk);
            hold = o_data;
            @(negedge clk);
            check(o_valid && o_data == hold, "R6", longint'(o_data), longint'(hold));
         end
         o_ready = 1'b1;
         while (!o_valid) @(negedge clk);
         got = longint'($signed(o_data));
         check(got == expm[e/4][e%4], req, got, expm[e/4][e%4]);
         check(o_last == (e == 15), "R5", longint'(o_last), longint'(e == 15));
         @(posedge clk);
         #1 o_ready = 1'b0;
      end
      @(negedge clk);
      check(a_ready && b_ready && !o_valid, "R9", longint'({a_ready, b_ready, o_valid}), 6);
   endtask

   // one tile on the odd-length instance
   task automatic odd_tile(input bit accum, input string req);
      longint dot, got;
      acc_en = accum;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         a2_valid = 1'b1;
         for (int k = 0; k < 5; k++) a2_data[k*8 +: 8] = 8'(A2[i][k]);
         while (!a2_ready) @(negedge clk);
         @(posedge clk);
         #1 a2_valid = 1'b0;
      end
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         b2_valid = 1'b1;
         for (int k = 0; k < 5; k++) b2_data[k*8 +: 8] = 8'(B2[k][j]);
         while (!b2_ready) @(negedge clk);
         @(posedge clk);
         #1 b2_valid = 1'b0;
      end
      for (int i = 0; i < 2; i++)
         for (int j = 0; j < 3; j++) begin
            dot = 0;
            for (int k = 0; k < 5; k++) dot += longint'(A2[i][k]) * longint'(B2[k][j]);
            exp2[i][j] = (accum ? exp2[i][j] : 0) + dot;
         end
      for (int e = 0; e < 6; e++) begin
         @(negedge clk);
         o_ready = 1'b1;
         while (!o2_valid) @(negedge clk);
         got = longint'($signed(o2_data));
         check(got == exp2[e/3][e%3], req, got, exp2[e/3][e%3]);
         check(o2_last == (e == 5), "R5", longint'(o2_last), longint'(e == 5));
         @(posedge clk);
         #1 o_ready = 1'b0;
      end
   endtask

   task automatic fill_main(input int mode);
      for (int i = 0; i < 4; i++)
         for (int k = 0; k < 8; k++) begin
            case (mode)
               0: A[i][k] = int'($urandom_range(255)) - 128;
               1: A[i][k] = -128;
               default: A[i][k] = ((i + k) % 2 == 0) ? 127 : -128;
            endcase
         end
      for (int k = 0; k < 8; k++)
         for (int j = 0; j < 4; j++) begin
            case (mode)
               0: B[k][j] = int'($urandom_range(255)) - 128;
               1: B[k][j] = -128;
               default: B[k][j] = ((k + j) % 3 == 0) ? -128 : 127;
            endcase
         end
   endtask

   task automatic fill_odd(input bit all_min);
      for (int i = 0; i < 2; i++)
         for (int k = 0; k < 5; k++)
            A2[i][k] = all_min ? -128 : int'($urandom_range(255)) - 128;
      for (int k = 0; k < 5; k++)
         for (int j = 0; j < 3; j++)
            B2[k][j] = all_min ? -128 : int'($urandom_range(255)) - 128;
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(a_ready && b_ready && !o_valid, "R1", longint'({a_ready, b_ready, o_valid}), 6);
      check(a2_ready && b2_ready && !o2_valid, "R1", longint'({a2_ready, b2_ready, o2_valid}), 6);
   endtask

   task automatic test_clear();
      fill_main(0);
      acc_en = 1'b1;
      send_a_row(0);
      send_a_row(1);
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check(a_ready && b_ready && !o_valid, "R8", longint'({a_ready, b_ready, o_valid}), 6);
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) expm[i][j] = 0;
      main_tile(1'b1, 1'b0, "R8");
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R9: watchdog expired, got %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++) expm[i][j] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      fill_main(0);
      main_tile(1'b0, 1'b1, "R3");
      fill_main(0);
      main_tile(1'b1, 1'b0, "R7");
      fill_main(1);
      main_tile(1'b0, 1'b0, "R3");
      main_tile(1'b1, 1'b1, "R7");
      fill_main(2);
      main_tile(1'b0, 1'b0, "R3");
      fill_main(0);
      main_tile(1'b0, 1'b0, "R7");
      test_clear();
      fill_odd(1'b0);
      odd_tile(1'b0, "R4");
      fill_odd(1'b1);
      odd_tile(1'b0, "R4");
      fill_odd(1'b0);
      odd_tile(1'b1, "R4");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule